// File: doc/BRIEF.md
# SCSI Initiator Bus-Free Check and Target Selection Sequencer

This block is the initiator-side front end of a parallel SCSI controller. A host pulses `start_i` with a target address byte on `target_id_i`. The block then confirms that the bus is idle and places that byte on the data lines while asserting SEL. Once the target answers with BSY, the block withdraws from the bus and waits for the target's first REQ. It then checks that the target has moved into command phase. When it finishes, it pulses `done_o` and gives an error code. On success it also holds the decoded phase on `phase_o` for the data-transfer logic that follows.

All bus pins are open-collector style. Each output is a drive enable: a 1 pulls the line to its asserted level. Each input is the line's asserted level as seen on the bus. Inputs pass through a two-flop synchronizer before any decision uses them. A failed selection step pulls RST for a fixed number of cycles before completion is reported. A bus that never becomes free leaves a sticky flag, and the next start then resets the bus before it does anything else. The host can also request a stand-alone bus reset. Gap, pulse width, retry count and timeouts are all parameters in clock cycles.

Top module: `scsi_sel_seq`

## Requirements
- R1: After `rst` and before any request, `sel_oe_o`, `rst_oe_o`, `data_oe_o`, `done_o` and `phase_vld_o` are 0 and `data_o` is 0.
- R2: With an idle bus, the bus is tested twice, FREE_GAP cycles apart. The first test happens right after the start is taken. SEL is then asserted, with `sel_oe_o` going high exactly FREE_GAP+3 cycles after the clock edge that samples `start_i`.
- R3: A busy bus (BSY or SEL seen on a test) restarts the free check. A retry count of fewer than FREE_TRIES busy tests only delays selection. FREE_TRIES busy tests end the attempt with `done_o` and `err_o`=1, with no RST pulse.
- R4: After an `err_o`=1 result, the next start first drives an RST pulse and then carries out the normal free check and selection.
- R5: While `sel_oe_o` is high, `data_oe_o` is high and `data_o` equals the target byte taken at start.
- R6: When BSY is seen, SEL and the data drivers are released together. If REQ is not seen within REQ_TMO cycles, the block resets the bus and reports `err_o`=3.
- R7: If BSY is not seen within BSY_TMO cycles of asserting SEL, the block resets the bus and reports `err_o`=2. A BSY seen on the last cycle of the window wins over the timeout.
- R8: On REQ, the phase code {MSG,C/D,I/O} is decoded. A code of 2 (command) gives `done_o` with `err_o`=0, `phase_o`=2 and `phase_vld_o`=1. Any other code resets the bus and gives `err_o`=4.
- R9: A bus reset holds `rst_oe_o` high for exactly RST_WIDTH cycles. During that time `sel_oe_o` and `data_oe_o` stay low and `data_o` stays 0. For a failure, `done_o` follows the end of the pulse.
- R10: A `reset_req_i` pulse while idle produces one RST pulse, then `done_o` with `err_o`=5, and clears `phase_vld_o`.
- R11: `done_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a selection (taken when idle) |
| reset_req_i | input | 1 | Request a stand-alone bus reset (taken when idle) |
| target_id_i | input | ID_W | Target address byte, sampled with start |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code: 0 ok, 1 bus not free, 2 BSY timeout, 3 REQ timeout, 4 wrong phase, 5 reset done |
| phase_vld_o | output | 1 | Decoded phase valid after a successful selection |
| phase_o | output | 3 | Decoded phase code {MSG,C/D,I/O} |
| bsy_i | input | 1 | BSY line asserted |
| sel_i | input | 1 | SEL line asserted |
| req_i | input | 1 | REQ line asserted |
| phase_i | input | 3 | {MSG,C/D,I/O} line levels |
| sel_oe_o | output | 1 | Pull SEL |
| rst_oe_o | output | 1 | Pull RST |
| data_oe_o | output | 1 | Enable data line drivers |
| data_o | output | ID_W | Data line values while driving |

## Verification
The arrival of the target's BSY and the expiry of the selection timeout can fall in the same cycle. The design resolves this in favour of BSY. The bench's target model delays its BSY answer by a programmable count, and two table rows place the synchronized BSY on the last cycle of the window and one cycle beyond it. The first row must end in a clean command-phase result and the second in error code 2 with a reset pulse. A second overlap comes from a busy bus that clears just before the retry limit: selection must then start at a precisely computed later cycle, not fail.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSRST,
    ST_FREE_A,
    ST_GAP,
    ST_FREE_B,
    ST_SEL,
    ST_WREQ
  } sel_state_t;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_NOT_FREE = 3'd1;
  localparam logic [2:0] ERR_BSY_TMO  = 3'd2;
  localparam logic [2:0] ERR_REQ_TMO  = 3'd3;
  localparam logic [2:0] ERR_PHASE    = 3'd4;
  localparam logic [2:0] ERR_RST_DONE = 3'd5;

  localparam logic [2:0] PH_COMMAND = 3'd2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scsi_sel_sync.sv
module scsi_sel_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[g] <= 1'b0;
        q_o[g]  <= 1'b0;
      end else begin
        meta[g] <= d_i[g];
        q_o[g]  <= meta[g];
      end
    end
  end
endmodule

// File: rtl/scsi_sel_tmr.sv
module scsi_sel_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (cnt != {W{1'b1}})
      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_sel_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int FREE_GAP   = 250,
  parameter int FREE_TRIES = 1000,
  parameter int RST_WIDTH  = 3125,
  parameter int BSY_TMO    = 50000,
  parameter int REQ_TMO    = 50000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            reset_req_i,
  input  logic [ID_W-1:0] target_id_i,
  output logic            done_o,
  output logic [2:0]      err_o,
  output logic            phase_vld_o,
  output logic [2:0]      phase_o,
  input  logic            bsy_i,
  input  logic            sel_i,
  input  logic            req_i,
  input  logic [2:0]      phase_i,
  output logic            sel_oe_o,
  output logic            rst_oe_o,
  output logic            data_oe_o,
  output logic [ID_W-1:0] data_o
);
  localparam int MAXT = imax(imax(FREE_GAP, RST_WIDTH), imax(BSY_TMO, REQ_TMO));
  localparam int TW   = $clog2(MAXT + 1);
  localparam int CW   = $clog2(FREE_TRIES + 1);
  localparam int SW   = 6;

  // synchronized bus inputs
  logic [SW-1:0] sync_q;
  logic          bsy_s, sel_s, req_s;
  logic [2:0]    phase_s;

  scsi_sel_sync #(.N(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bsy_i, sel_i, req_i, phase_i}),
    .q_o (sync_q)
  );
  assign {bsy_s, sel_s, req_s, phase_s} = sync_q;

  sel_state_t    state, state_n;
  logic [TW-1:0] cnt;
  logic          tmr_clr;
  logic [CW-1:0] tries;
  logic          tries_inc, tries_clr;
  logic          need_rst, set_need, clr_need;
  logic          resume, resume_n;
  logic [2:0]    pend, pend_n, rep_code;
  logic          report, succeed, take_id, clr_pvld;
  logic [ID_W-1:0] id_q;
  logic          busy;

  assign busy    = bsy_s | sel_s;
  assign tmr_clr = (state_n != state);

  scsi_sel_tmr #(.W(TW)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (cnt)
  );

  always_comb begin
    state_n   = state;
    report    = 1'b0;
    succeed   = 1'b0;
    rep_code  = pend;
    tries_inc = 1'b0;
    tries_clr = 1'b0;
    set_need  = 1'b0;
    clr_need  = 1'b0;
    pend_n    = pend;
    resume_n  = resume;
    take_id   = 1'b0;
    clr_pvld  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_i) begin
          take_id   = 1'b1;
          tries_clr = 1'b1;
          clr_pvld  = 1'b1;
          if (need_rst) begin
            state_n  = ST_BUSRST;
            resume_n = 1'b1;
            pend_n   = ERR_NONE;
            clr_need = 1'b1;
          end else begin
            state_n = ST_FREE_A;
          end
        end else if (reset_req_i) begin
          state_n  = ST_BUSRST;
          resume_n = 1'b0;
          pend_n   = ERR_RST_DONE;
          clr_pvld = 1'b1;
          clr_need = 1'b1;
        end
      end
      ST_BUSRST: begin
        if (cnt == TW'(RST_WIDTH - 1)) begin
          if (resume) begin
            state_n = ST_FREE_A;
          end else begin
            state_n = ST_IDLE;
            report  = 1'b1;
          end
        end
      end
      ST_FREE_A, ST_FREE_B: begin
        if (busy) begin
          if (tries == CW'(FREE_TRIES - 1)) begin
            state_n  = ST_IDLE;
            report   = 1'b1;
            rep_code = ERR_NOT_FREE;
            set_need = 1'b1;
          end else begin
            tries_inc = 1'b1;
            state_n   = ST_FREE_A;
          end
        end else begin
          state_n = (state == ST_FREE_A) ? ST_GAP : ST_SEL;
        end
      end
      ST_GAP: begin
        if (cnt == TW'(FREE_GAP - 1))
          state_n = ST_FREE_B;
      end
      ST_SEL: begin
        // a seen BSY wins over an expiring window
        if (bsy_s) begin
          state_n = ST_WREQ;
        end else if (cnt == TW'(BSY_TMO - 1)) begin
          state_n  = ST_BUSRST;
          pend_n   = ERR_BSY_TMO;
          resume_n = 1'b0;
        end
      end
      ST_WREQ: begin
        if (req_s) begin
          if (phase_s == PH_COMMAND) begin
            state_n = ST_IDLE;
            succeed = 1'b1;
          end else begin
            state_n  = ST_BUSRST;
            pend_n   = ERR_PHASE;
            resume_n = 1'b0;
          end
        end else if (cnt == TW'(REQ_TMO - 1)) begin
          state_n  = ST_BUSRST;
          pend_n   = ERR_REQ_TMO;
          resume_n = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tries       <= '0;
      need_rst    <= 1'b0;
      resume      <= 1'b0;
      pend        <= ERR_NONE;
      id_q        <= '0;
      done_o      <= 1'b0;
      err_o       <= ERR_NONE;
      phase_o     <= '0;
      phase_vld_o <= 1'b0;
      sel_oe_o    <= 1'b0;
      rst_oe_o    <= 1'b0;
      data_oe_o   <= 1'b0;
      data_o      <= '0;
    end else begin
      state  <= state_n;
      resume <= resume_n;
      pend   <= pend_n;
      if (tries_clr)      tries <= '0;
      else if (tries_inc) tries <= tries + CW'(1);
      if (set_need)      need_rst <= 1'b1;
      else if (clr_need) need_rst <= 1'b0;
      if (take_id) id_q <= target_id_i;
      done_o <= report | succeed;
      if (report)       err_o <= rep_code;
      else if (succeed) err_o <= ERR_NONE;
      if (succeed) begin
        phase_o     <= phase_s;
        phase_vld_o <= 1'b1;
      end else if (clr_pvld) begin
        phase_vld_o <= 1'b0;
      end
      sel_oe_o  <= (state_n == ST_SEL);
      data_oe_o <= (state_n == ST_SEL);
      rst_oe_o  <= (state_n == ST_BUSRST);
      data_o    <= (state_n == ST_SEL) ? id_q : '0;
    end
  end

  // R5: address byte present on the bus for the whole of SEL
  p_sel_drives_id_r5: assert property (@(posedge clk) disable iff (rst)
    sel_oe_o |-> (data_oe_o && data_o == id_q));

  // R6: SEL and the data drivers drop together
  p_release_together_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_oe_o) |-> !data_oe_o);

  // R9: nothing else driven while RST is pulled
  p_rst_alone_r9: assert property (@(posedge clk) disable iff (rst)
    rst_oe_o |-> (!sel_oe_o && !data_oe_o && data_o == '0));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: a clean result always carries the command phase
  p_ok_is_command_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o == ERR_NONE) |-> (phase_vld_o && phase_o == PH_COMMAND));

  // R4: sticky flag forces a reset before anything else
  p_sticky_reset_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_i && need_rst) |=> rst_oe_o);

endmodule

// File: tb/test_scsi_sel_seq.sv
module test_scsi_sel_seq;
  localparam int ID_W  = 8;
  localparam int GAP   = 4;
  localparam int TRIES = 5;
  localparam int RW    = 8;
  localparam int BTMO  = 16;
  localparam int QTMO  = 16;
  localparam int NV    = 8;

  // {id[20:13], bsy_en[12], dly[11:7], req_en[6], phase[5:3], exp_err[2:0]}
  localparam logic [20:0] VEC [NV] = '{
    {8'h01, 1'b1, 5'd0,  1'b1, 3'd2, 3'd0},
    {8'h80, 1'b1, 5'd3,  1'b1, 3'd2, 3'd0},
    {8'h24, 1'b0, 5'd0,  1'b0, 3'd0, 3'd2},
    {8'h11, 1'b1, 5'd0,  1'b0, 3'd0, 3'd3},
    {8'h02, 1'b1, 5'd0,  1'b1, 3'd3, 3'd4},
    {8'h04, 1'b1, 5'd1,  1'b1, 3'd0, 3'd4},
    {8'h55, 1'b1, 5'd12, 1'b1, 3'd2, 3'd0},
    {8'h66, 1'b1, 5'd13, 1'b1, 3'd2, 3'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, reset_req_i = 1'b0;
  logic [ID_W-1:0] target_id_i = '0;
  logic done_o, phase_vld_o, sel_oe_o, rst_oe_o, data_oe_o;
  logic [2:0] err_o, phase_o;
  logic [ID_W-1:0] data_o;
  logic bsy_i, sel_i, req_i;
  logic [2:0] phase_i;

  always #4 clk = ~clk;

  // target model
  logic t_bsy = 1'b0, t_req = 1'b0, t_rel = 1'b0, bus_force = 1'b0;
  logic t_bsy_en = 1'b0, t_req_en = 1'b0;
  logic [2:0] t_ph = '0, t_ph_cfg = '0;
  int t_dly = 0, scnt = 0;

  always @(posedge clk) begin
    if (rst_oe_o || t_rel) begin
      t_bsy <= 1'b0; t_req <= 1'b0; t_ph <= '0; scnt <= 0;
    end else begin
      if (sel_oe_o && t_bsy_en) begin
        if (scnt == t_dly) t_bsy <= 1'b1;
        if (scnt < 1000) scnt <= scnt + 1;
      end else begin
        scnt <= 0;
      end
      if (t_bsy && !sel_oe_o && t_req_en) begin
        t_req <= 1'b1; t_ph <= t_ph_cfg;
      end
    end
  end

  assign bsy_i   = t_bsy;
  assign sel_i   = bus_force;
  assign req_i   = t_req;
  assign phase_i = t_ph;

  scsi_sel_seq #(
    .ID_W(ID_W), .FREE_GAP(GAP), .FREE_TRIES(TRIES), .RST_WIDTH(RW),
    .BSY_TMO(BTMO), .REQ_TMO(QTMO)
  ) i_scsi_sel_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .reset_req_i(reset_req_i),
    .target_id_i(target_id_i), .done_o(done_o), .err_o(err_o),
    .phase_vld_o(phase_vld_o), .phase_o(phase_o), .bsy_i(bsy_i),
    .sel_i(sel_i), .req_i(req_i), .phase_i(phase_i), .sel_oe_o(sel_oe_o),
    .rst_oe_o(rst_oe_o), .data_oe_o(data_oe_o), .data_o(data_o)
  );

  int total = 0, bad = 0;
  int r_err, r_ph, r_vld, r_sel_lat, r_rst_cyc, r_bad, r_id, r_to, r_done2;
  int wd = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input bit is_rreq, input int busy_cycles);
    int cyc;
    int left;
    left = busy_cycles;
    r_sel_lat = -1; r_rst_cyc = 0; r_bad = 0; r_id = 0; r_to = 0;
    @(negedge clk);
    if (is_rreq) reset_req_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; reset_req_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 3000) begin
      if (left > 0) begin
        left--;
        if (left == 0) bus_force = 1'b0;
      end
      if (sel_oe_o && r_sel_lat < 0) begin
        r_sel_lat = cyc; r_id = int'(data_o);
      end
      if (sel_oe_o != data_oe_o) r_bad = 1;
      if (rst_oe_o && (sel_oe_o || data_oe_o || data_o != '0)) r_bad = 1;
      if (rst_oe_o) r_rst_cyc++;
      @(negedge clk);
      cyc++;
    end
    if (!done_o) r_to = 1;
    r_err = int'(err_o); r_ph = int'(phase_o); r_vld = int'(phase_vld_o);
    @(negedge clk);
    r_done2 = int'(done_o);
  endtask

  task automatic release_bus();
    @(negedge clk); t_rel = 1'b1;
    repeat (2) @(negedge clk);
    t_rel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_ok();
    t_bsy_en = 1'b1; t_dly = 0; t_req_en = 1'b1; t_ph_cfg = 3'd2;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_oe", int'(sel_oe_o), 0);
    chk("R1 rst_oe", int'(rst_oe_o), 0);
    chk("R1 data_oe", int'(data_oe_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 phase_vld", int'(phase_vld_o), 0);
    chk("R1 data", int'(data_o), 0);

    // table of selection scenarios (R2 R5 R6 R7 R8 R9 R11)
    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      target_id_i = e[20:13];
      t_bsy_en = e[12]; t_dly = int'(e[11:7]); t_req_en = e[6];
      t_ph_cfg = e[5:3];
      do_cmd(1'b0, 0);
      chk("R11 completion seen", r_to, 0);
      chk("R6 R7 R8 result code", r_err, int'(e[2:0]));
      chk("R2 sel latency", r_sel_lat, GAP + 3);
      chk("R5 id on bus", r_id, int'(e[20:13]));
      chk("R5 R9 drive rules", r_bad, 0);
      chk("R11 done single", r_done2, 0);
      if (e[2:0] == 3'd0) begin
        chk("R8 phase", r_ph, 2);
        chk("R8 phase_vld", r_vld, 1);
        chk("R9 no reset on success", r_rst_cyc, 0);
      end else begin
        chk("R9 reset width", r_rst_cyc, RW);
        chk("R8 phase_vld low", r_vld, 0);
      end
      release_bus();
    end

    // R3 bus held busy: not-free failure, no reset
    cfg_ok();
    target_id_i = 8'h08;
    bus_force = 1'b1;
    repeat (4) @(negedge clk);
    do_cmd(1'b0, 0);
    chk("R3 not free code", r_err, 1);
    chk("R3 no reset", r_rst_cyc, 0);
    chk("R3 no select", r_sel_lat, -1);
    bus_force = 1'b0;
    repeat (4) @(negedge clk);

    // R4 sticky reset before next selection
    do_cmd(1'b0, 0);
    chk("R4 result", r_err, 0);
    chk("R4 reset first", r_rst_cyc, RW);
    chk("R4 phase_vld", r_vld, 1);
    chk("R4 id", r_id, 8'h08);
    release_bus();

    // R10 reset request clears phase valid
    do_cmd(1'b1, 0);
    chk("R10 code", r_err, 5);
    chk("R10 width", r_rst_cyc, RW);
    chk("R10 phase_vld cleared", r_vld, 0);
    chk("R10 no select", r_sel_lat, -1);
    chk("R11 done single", r_done2, 0);
    release_bus();

    // R3 short busy: retries delay selection only
    cfg_ok();
    target_id_i = 8'h21;
    bus_force = 1'b1;
    repeat (3) @(negedge clk);
    do_cmd(1'b0, 2);
    chk("R3 short busy result", r_err, 0);
    chk("R3 delayed sel latency", r_sel_lat, GAP + 6);
    chk("R3 no reset", r_rst_cyc, 0);
    release_bus();

    finish_run();
  end
endmodule